// File: doc/BRIEF.md
# Byte-Oriented Two-Wire Bus Master Transmitter

This block is a master transmitter for a two-wire serial bus (I2C). Software works it through a small register file. Two control addresses act on one control register: writing a 1 to a bit at one address sets that bit, and writing a 1 at the other address clears it. A data register holds the next byte to send. A read-only status register holds an eight-bit code. Two count registers set how long SCL stays high and how long it stays low.

The block stops after every bus event: a START, an address byte with its acknowledge, a data byte with its acknowledge, or a lost arbitration. At each stop it raises an interrupt flag and publishes a status code, and software picks its next action from that code. The hardware does not move on until software clears the flag through the clear address. Both bus lines are open-drain. The block only pulls a line low or releases it, and it reads the real line level back through `scl_i` and `sda_i`. These inputs are assumed to be already synchronous to `clk`.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0xF8, both SCL count registers read 4, `irq` is 0, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: Register addresses are: 0 set-control, 1 status, 2 data, 3 clear-control, 4 SCL high count, 5 SCL low count. Control bits are enable 6, start request 5, stop request 4, interrupt flag 3, acknowledge-enable 2; addresses 0 and 3 both read the control register. The flag is cleared only by writing 1 to bit 3 at address 3; a write of 0x08 to address 0 leaves it unchanged.
- R3: With enable and start request set, a START (SDA pulled low while SCL is released) is issued only once both lines read high; after it, the flag is set and status reads 0x08.
- R4: The first byte after a START is the contents of the data register, shifted out MSB first, followed by a released acknowledge bit; the flag is then set with status 0x18 if SDA was low in the acknowledge bit and 0x20 if it was high.
- R5: Each later byte is shifted out MSB first; afterwards the flag is set with status 0x28 on acknowledge and 0x30 on no acknowledge.
- R6: If SDA reads low at the end of an SCL high phase in which the block released SDA for a data or address bit, the block sets the flag, status reads 0x38, and both lines are released; clearing the flag then returns status to 0xF8.
- R7: If the stop request is set when the flag is cleared, the block pulls SDA low, releases SCL, and then releases SDA while SCL is high. The stop request bit then clears itself, status reads 0xF8, and the flag stays 0.
- R8: Whenever the flag is set and status is not 0x38, SCL is pulled low.
- R9: During a transferred bit, SCL stays released for (high count + 1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check on every cycle that SCL stays low while the flag waits and that the flag never drops without a write to the clear address. They also check that a lost arbitration leaves both lines released, that every rise of the flag comes with a legal status code, and that an SDA release while SCL is high is always a STOP. Several things can only be shown by the bench's scenarios: the bit order of the bytes on the wire, whether the acknowledge and no-acknowledge codes follow the bus, how long the SCL high phase lasts for different count values, that START waits while the bus is held busy, and that the stop request clears itself.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_H,
        ST_START_L,
        ST_HOLD,
        ST_BIT_L,
        ST_BIT_H,
        ST_LOST,
        ST_STOP_L,
        ST_STOP_H
    } mst_state_e;

    // control bit positions (software decodes these)
    localparam int B_EN  = 6;
    localparam int B_STA = 5;
    localparam int B_STO = 4;
    localparam int B_SI  = 3;
    localparam int B_AA  = 2;

    // register addresses
    localparam logic [2:0] A_SET  = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_DATA = 3'd2;
    localparam logic [2:0] A_CLR  = 3'd3;
    localparam logic [2:0] A_HI   = 3'd4;
    localparam logic [2:0] A_LO   = 3'd5;

    // status codes
    localparam logic [7:0] SC_START     = 8'h08;
    localparam logic [7:0] SC_ADDR_ACK  = 8'h18;
    localparam logic [7:0] SC_ADDR_NACK = 8'h20;
    localparam logic [7:0] SC_DATA_ACK  = 8'h28;
    localparam logic [7:0] SC_DATA_NACK = 8'h30;
    localparam logic [7:0] SC_ARB_LOST  = 8'h38;
    localparam logic [7:0] SC_IDLE      = 8'hF8;

endpackage

// File: rtl/i2c_mtx_timer.sv
module i2c_mtx_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/i2c_mtx_shift.sv
module i2c_mtx_shift #(
    parameter int DW  = 8,
    parameter int SCW = $clog2(DW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [DW-1:0]  din,
    input  logic           shift,
    output logic           msb,
    output logic [SCW-1:0] cnt
);
    logic [DW-1:0]  sh_d, sh_q;
    logic [SCW-1:0] cnt_d, cnt_q;

    always_comb begin
        sh_d  = sh_q;
        cnt_d = cnt_q;
        if (load) begin
            sh_d  = din;
            cnt_d = '0;
        end else if (shift) begin
            // ones fill: after the last data bit the line is released for acknowledge
            sh_d  = {sh_q[DW-2:0], 1'b1};
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end else begin
            sh_q  <= sh_d;
            cnt_q <= cnt_d;
        end
    end

    assign msb = sh_q[DW-1];
    assign cnt = cnt_q;
endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
    import i2c_mtx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HI_RST = 4,
    parameter int LO_RST = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam int DW  = 8;
    localparam int SCW = $clog2(DW + 1);

    typedef struct packed {
        mst_state_e       st;
        logic             en;
        logic             sta;
        logic             sto;
        logic             si;
        logic             aa;
        logic [7:0]       status;
        logic [DW-1:0]    data;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic             addr_ph;
        logic             scl_low;
        logic             sda_low;
    } regs_t;

    regs_t            cur_q, nxt_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_msb;
    logic [SCW-1:0]   sh_cnt;
    logic             si_rel;
    logic             ack;
    logic [7:0]       stat_code;
    logic [7:0]       ctrl_rd;

    i2c_mtx_timer #(.CW(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .done (tmr_done)
    );

    i2c_mtx_shift #(.DW(DW), .SCW(SCW)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (sh_load),
        .din  (cur_q.data),
        .shift(sh_shift),
        .msb  (sh_msb),
        .cnt  (sh_cnt)
    );

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = cur_q.lo;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        ack      = ~sda_i;
        si_rel   = reg_wr && (reg_addr == A_CLR) && reg_wdata[B_SI] && cur_q.si;

        // software side
        if (reg_wr) begin
            case (reg_addr)
                A_SET: begin
                    nxt_d.en  = cur_q.en  | reg_wdata[B_EN];
                    nxt_d.sta = cur_q.sta | reg_wdata[B_STA];
                    nxt_d.sto = cur_q.sto | reg_wdata[B_STO];
                    nxt_d.aa  = cur_q.aa  | reg_wdata[B_AA];
                end
                A_CLR: begin
                    nxt_d.en  = cur_q.en  & ~reg_wdata[B_EN];
                    nxt_d.sta = cur_q.sta & ~reg_wdata[B_STA];
                    nxt_d.aa  = cur_q.aa  & ~reg_wdata[B_AA];
                    nxt_d.si  = cur_q.si  & ~reg_wdata[B_SI];
                end
                A_DATA:  nxt_d.data = reg_wdata;
                A_HI:    nxt_d.hi   = CNT_W'(reg_wdata);
                A_LO:    nxt_d.lo   = CNT_W'(reg_wdata);
                default: ;
            endcase
        end

        // bus side
        case (cur_q.st)
            ST_IDLE: begin
                nxt_d.scl_low = 1'b0;
                nxt_d.sda_low = 1'b0;
                if (cur_q.en && cur_q.sta && scl_i && sda_i) begin
                    nxt_d.st      = ST_START_H;
                    nxt_d.sda_low = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = cur_q.hi;
                end
            end
            ST_START_H: begin
                if (tmr_done) begin
                    nxt_d.st      = ST_START_L;
                    nxt_d.scl_low = 1'b1;
                    tmr_load      = 1'b1;
                end
            end
            ST_START_L: begin
                if (tmr_done) begin
                    nxt_d.st      = ST_HOLD;
                    nxt_d.si      = 1'b1;
                    nxt_d.status  = SC_START;
                    nxt_d.addr_ph = 1'b1;
                end
            end
            ST_HOLD: begin
                nxt_d.scl_low = 1'b1;
                if (si_rel) begin
                    tmr_load = 1'b1;
                    if (cur_q.sto) begin
                        nxt_d.st      = ST_STOP_L;
                        nxt_d.sda_low = 1'b1;
                    end else begin
                        nxt_d.st = ST_BIT_L;
                        sh_load  = 1'b1;
                    end
                end
            end
            ST_BIT_L: begin
                nxt_d.sda_low = ~sh_msb;
                if (tmr_done) begin
                    nxt_d.st      = ST_BIT_H;
                    nxt_d.scl_low = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = cur_q.hi;
                end
            end
            ST_BIT_H: begin
                if (tmr_done) begin
                    if (sh_cnt == SCW'(DW)) begin
                        nxt_d.st      = ST_HOLD;
                        nxt_d.scl_low = 1'b1;
                        nxt_d.si      = 1'b1;
                        nxt_d.addr_ph = 1'b0;
                        if (cur_q.addr_ph) nxt_d.status = ack ? SC_ADDR_ACK : SC_ADDR_NACK;
                        else               nxt_d.status = ack ? SC_DATA_ACK : SC_DATA_NACK;
                    end else if (!cur_q.sda_low && !sda_i) begin
                        nxt_d.st      = ST_LOST;
                        nxt_d.scl_low = 1'b0;
                        nxt_d.sda_low = 1'b0;
                        nxt_d.si      = 1'b1;
                        nxt_d.status  = SC_ARB_LOST;
                    end else begin
                        nxt_d.st      = ST_BIT_L;
                        nxt_d.scl_low = 1'b1;
                        sh_shift      = 1'b1;
                        tmr_load      = 1'b1;
                    end
                end
            end
            ST_LOST: begin
                nxt_d.scl_low = 1'b0;
                nxt_d.sda_low = 1'b0;
                if (si_rel) begin
                    nxt_d.st     = ST_IDLE;
                    nxt_d.status = SC_IDLE;
                end
            end
            ST_STOP_L: begin
                if (tmr_done) begin
                    nxt_d.st      = ST_STOP_H;
                    nxt_d.scl_low = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = cur_q.hi;
                end
            end
            ST_STOP_H: begin
                if (tmr_done) begin
                    nxt_d.st      = ST_IDLE;
                    nxt_d.sda_low = 1'b0;
                    nxt_d.sto     = 1'b0;
                    nxt_d.status  = SC_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.st      <= ST_IDLE;
            cur_q.status  <= SC_IDLE;
            cur_q.hi      <= CNT_W'(HI_RST);
            cur_q.lo      <= CNT_W'(LO_RST);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stat_code = cur_q.status;
    assign ctrl_rd   = {1'b0, cur_q.en, cur_q.sta, cur_q.sto, cur_q.si, cur_q.aa, 2'b00};

    always_comb begin
        case (reg_addr)
            A_SET, A_CLR: reg_rdata = ctrl_rd;
            A_STAT:       reg_rdata = stat_code;
            A_DATA:       reg_rdata = cur_q.data;
            A_HI:         reg_rdata = 8'(cur_q.hi);
            A_LO:         reg_rdata = 8'(cur_q.lo);
            default:      reg_rdata = 8'h00;
        endcase
    end

    assign irq    = cur_q.si;
    assign scl_oe = cur_q.scl_low;
    assign sda_oe = cur_q.sda_low;
endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] stat_code
);
    // R8: a waiting flag holds the clock low unless arbitration was lost
    assert_flag_hold_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && stat_code != 8'h38) |-> scl_oe);

    // R2: the flag drops only after a write to the clear address
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_addr == 3'd3)) |=> irq);

    // R6: lost arbitration leaves both lines free
    assert_lost_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && stat_code == 8'h38) |-> (!scl_oe && !sda_oe));

    // R4: every raised flag carries a legal code
    assert_flag_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat_code == 8'h08 || stat_code == 8'h18 || stat_code == 8'h20 ||
                        stat_code == 8'h28 || stat_code == 8'h30 || stat_code == 8'h38));

    // R7: releasing SDA while SCL is free is a STOP, ending in the idle code
    assert_stop_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> stat_code == 8'hF8);
endmodule

bind i2c_mtx_ctrl i2c_mtx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .irq      (irq),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .stat_code(stat_code)
);

// File: tb/i2c_mtx_ctrl_tb.sv
module i2c_mtx_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_i, sda_i;

    // bus model
    logic       bus_scl_low = 1'b0;
    logic       slv_low = 1'b0;
    logic       ack_cfg = 1'b1;
    logic       arb_mode = 1'b0;
    logic       arb_drop = 1'b0;
    logic       scl_p = 1'b1, sda_p = 1'b1;
    int         bitn = 0;
    logic [7:0] shreg = 8'h00, cap = 8'h00;
    int         hcnt = 0, hlast = 0;
    logic       stop_seen = 1'b0;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    assign scl_i = !(scl_oe || bus_scl_low);
    assign sda_i = !(sda_oe || slv_low);

    always #10 clk = ~clk;

    i2c_mtx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // slave / monitor
    always @(posedge clk) begin
        scl_p <= scl_i;
        sda_p <= sda_i;
        if (scl_i && scl_p && sda_p && !sda_i) begin
            bitn <= 0;
        end else if (scl_i && scl_p && !sda_p && sda_i) begin
            bitn      <= 0;
            stop_seen <= 1'b1;
        end else if (!scl_p && scl_i) begin
            if (bitn < 8) shreg <= {shreg[6:0], sda_i};
            bitn <= bitn + 1;
            hcnt <= 1;
        end else if (scl_p && !scl_i) begin
            hlast <= hcnt;
            if (arb_mode && bitn == 0) slv_low <= 1'b1;
            else if (bitn == 8) slv_low <= ack_cfg;
            else if (bitn == 9) begin
                slv_low <= 1'b0;
                bitn    <= 0;
                cap     <= shreg;
            end
        end else if (scl_i) begin
            hcnt <= hcnt + 1;
        end
        if (arb_drop) slv_low <= 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(irq == 1'b1, req, irq, 1);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s = 8'h00;
        for (int n = 0; n < 3000; n++) begin
            rd(3'd1, s);
            if (s == 8'hF8) break;
        end
        chk(s == 8'hF8, req, s, 8'hF8);
    endtask

    // {addr, data, hi[3:0], lo[3:0], addr_ack, data_ack, 2'b0}
    localparam logic [27:0] VEC [4] = '{
        {8'h52, 8'hC3, 4'd3, 4'd2, 1'b1, 1'b1, 2'b00},
        {8'hA4, 8'h5A, 4'd5, 4'd4, 1'b1, 1'b0, 2'b00},
        {8'h3E, 8'h01, 4'd2, 4'd3, 1'b0, 1'b1, 2'b00},
        {8'hFE, 8'h80, 4'd6, 4'd2, 1'b0, 1'b0, 2'b00}
    };

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, r); chk(r == 8'h00, "R1 ctrl", r, 8'h00);
        rd(3'd1, r); chk(r == 8'hF8, "R1 status", r, 8'hF8);
        rd(3'd4, r); chk(r == 8'd4, "R1 hi count", r, 4);
        chk(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines/irq",
            {irq, scl_oe, sda_oe}, 0);

        // vector walk: R4, R5, R7, R9
        for (int i = 0; i < 4; i++) begin
            logic [27:0] v;
            logic        good;
            v = VEC[i];
            wr(3'd4, {4'h0, v[11:8]});
            wr(3'd5, {4'h0, v[7:4]});
            ack_cfg = v[3];
            wr(3'd0, 8'h60);
            wait_irq("R3 start flag");
            rd(3'd1, r); chk(r == 8'h08, "R3 start code", r, 8'h08);
            wr(3'd2, v[27:20]);
            wr(3'd3, 8'h28);
            wait_irq("R4 addr flag");
            rd(3'd1, r);
            chk(r == (v[3] ? 8'h18 : 8'h20), "R4 addr code", r, v[3] ? 8'h18 : 8'h20);
            repeat (3) @(negedge clk);
            chk(cap == v[27:20], "R4 addr bits", cap, v[27:20]);
            chk(hlast == int'(v[11:8]) + 1, "R9 scl high", hlast, int'(v[11:8]) + 1);
            ack_cfg = v[2];
            wr(3'd2, v[19:12]);
            wr(3'd3, 8'h08);
            wait_irq("R5 data flag");
            rd(3'd1, r);
            chk(r == (v[2] ? 8'h28 : 8'h30), "R5 data code", r, v[2] ? 8'h28 : 8'h30);
            repeat (3) @(negedge clk);
            chk(cap == v[19:12], "R5 data bits", cap, v[19:12]);
            // R8: clock held low while the flag waits
            good = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!scl_oe || !irq) good = 1'b0;
            end
            chk(good, "R8 scl held", good, 1);
            stop_seen = 1'b0;
            wr(3'd0, 8'h10);
            wr(3'd3, 8'h08);
            wait_idle("R7 idle code");
            repeat (3) @(negedge clk);
            rd(3'd0, r);
            chk(r[4] == 1'b0 && irq == 1'b0, "R7 sto self-clear", {r[4], irq}, 0);
            chk(stop_seen && !scl_oe && !sda_oe, "R7 stop on bus",
                {stop_seen, scl_oe, sda_oe}, 3'b100);
        end

        // R3: start waits for a free bus
        bus_scl_low = 1'b1;
        wr(3'd0, 8'h60);
        repeat (40) @(negedge clk);
        chk(sda_oe == 1'b0 && irq == 1'b0, "R3 busy wait", {sda_oe, irq}, 0);
        bus_scl_low = 1'b0;
        wait_irq("R3 start after free");
        rd(3'd1, r); chk(r == 8'h08, "R3 code after wait", r, 8'h08);

        // R2: set write cannot clear the flag; bit layout
        wr(3'd0, 8'h08);
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R2 set keeps flag", irq, 1);
        rd(3'd3, r); chk(r == 8'h68, "R2 ctrl layout", r, 8'h68);

        // R7: stop directly after start
        wr(3'd0, 8'h10);
        wr(3'd3, 8'h28);
        wait_idle("R7 stop after start");
        rd(3'd0, r); chk(r == 8'h40, "R7 ctrl after stop", r, 8'h40);

        // R6: arbitration lost on the first address bit
        arb_mode = 1'b1;
        wr(3'd0, 8'h20);
        wait_irq("R6 start");
        wr(3'd2, 8'hA0);
        wr(3'd3, 8'h28);
        wait_irq("R6 lost flag");
        rd(3'd1, r); chk(r == 8'h38, "R6 lost code", r, 8'h38);
        chk(!scl_oe && !sda_oe, "R6 release", {scl_oe, sda_oe}, 0);
        arb_mode = 1'b0;
        @(negedge clk); arb_drop = 1'b1;
        @(negedge clk); arb_drop = 1'b0;
        wr(3'd3, 8'h08);
        repeat (2) @(negedge clk);
        rd(3'd1, r); chk(r == 8'hF8 && !irq, "R6 back to idle", r, 8'hF8);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule